// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host end of a three-wire, half-duplex link to an 8-bit serial converter. A one-cycle start request starts a frame. The block lowers chip select and produces a serial clock from the system clock. The serial clock's half-period is a parameter set in system clocks. On the one data wire the block first drives a start bit and a 3-bit configuration word. It then releases the wire to the converter.

The converter answers with one null bit, which is thrown away. Next come the eight result bits, most significant first. Last comes a repeat of result bits 1 through 7, least significant first. The host compares the two copies and raises a mismatch flag if they disagree, which exposes link errors. When the frame ends the block raises chip select. In that same cycle it pulses done and presents the registered result and mismatch flag. Busy covers the whole frame, and start requests made during a frame have no effect.

Top module: `adc_link_host`

## Requirements
- R1: After reset, and whenever no frame runs, cs_n_o is 1, sclk_o is 0, sdata_oe_o is 0, busy_o is 0 and done_o is 0. sclk_o is never 1 while cs_n_o is 1.
- R2: A start_i sampled while idle makes cs_n_o 0 and busy_o 1 on the next clock edge. The first rising edge of sclk_o comes exactly 2*HALF_DIV clocks after cs_n_o falls. Each sclk_o half-period lasts HALF_DIV clocks.
- R3: sdata_oe_o is 1 at the first four rising sclk_o edges. At these edges sdata_o carries 1, then cfg bit 2, cfg bit 1 and cfg bit 0. cfg_i is latched when the start is accepted. Outgoing bits change only when sclk_o falls or when the frame opens.
- R4: sdata_oe_o goes to 0 at the falling sclk_o edge after the fourth rising edge and stays 0 until the frame ends. It is 0 at rising edges 5 through 20.
- R5: The bit sampled at rising edge 5 (the null bit) is discarded. result_o is the bits sampled at rising edges 6..13, with edge 6 giving bit 7.
- R6: A frame has exactly 20 rising sclk_o edges. busy_o stays 1 for exactly 42*HALF_DIV clocks after acceptance. done_o is 1 for a single clock, in the same cycle that cs_n_o returns to 1 and busy_o returns to 0.
- R7: Rising edges 14..20 carry result bits 1..7 in that order. mismatch_o is 1 exactly when at least one of them differs from the same bit of result_o.
- R8: start_i asserted while busy_o is 1 is ignored. The frame timing, the configuration sent and the result are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, taken only when idle |
| cfg_i | input | CFG_W | Configuration word sent to the converter |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse when the frame ends |
| result_o | output | RES_W | Converted value, valid at done_o and held |
| mismatch_o | output | 1 | Repeat copy disagrees with the result |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| sdata_o | output | 1 | Outgoing data bit |
| sdata_oe_o | output | 1 | Drive enable for the shared data wire |
| sdata_i | input | 1 | Incoming data bit from the shared wire |

## Verification
Chip select and busy respond one clock after the start is accepted. The first serial rising edge is due 2*HALF_DIV clocks after chip select falls. done_o, result_o and mismatch_o are due exactly 42*HALF_DIV clocks after acceptance. The bench counts clocks on the falling system-clock edge from acceptance to the fall of busy. It expects done in the first sample after that, and expects done to be gone by the next sample. A converter model in the bench tags every serial rising edge with its index, so each sent bit, each drive-enable level and each returned bit is compared at its own numbered edge, not by absolute time.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  // Role of one serial clock within a frame, seen at its rising edge
  typedef enum logic [1:0] {
    SLOT_TX   = 2'd0,
    SLOT_NULL = 2'd1,
    SLOT_MSB  = 2'd2,
    SLOT_LSB  = 2'd3
  } slot_e;

endpackage

// File: rtl/adc_link_tick.sv
module adc_link_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt <= '0;
    end else if (cnt == CNT_TOP) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign tick_o = run_i && (cnt == CNT_TOP);
endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
  import adc_link_pkg::*;
#(
  parameter int CFG_W = 3,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             dout_o,
  output logic             oe_o,
  output logic             done_o,
  output logic             smp_o,
  output slot_e            slot_o,
  output logic             fin_o
);
  // serial clocks: start, config, null, result, repeat
  localparam int N_CLK   = 2 + CFG_W + 2 * RES_W - 1;
  localparam int LAST_PH = 2 * N_CLK + 2;
  localparam int PH_W    = $clog2(LAST_PH + 1);
  localparam int NULL_K  = CFG_W + 1;
  localparam int MSB_END = CFG_W + 1 + RES_W;

  logic [PH_W-1:0]  ph, ph_nxt, rise_k, fall_k;
  logic [CFG_W-1:0] tx_sh;
  logic             is_last, is_rise, is_fall;

  assign ph_nxt  = ph + PH_W'(1);
  assign rise_k  = (ph_nxt - PH_W'(2)) >> 1;
  assign fall_k  = (ph_nxt - PH_W'(3)) >> 1;
  assign is_last = (ph_nxt == PH_W'(LAST_PH));
  assign is_rise = !ph_nxt[0] && (ph_nxt >= PH_W'(2)) && !is_last;
  assign is_fall = ph_nxt[0] && (ph_nxt >= PH_W'(3));

  assign smp_o = busy_o && tick_i && is_rise;
  assign fin_o = busy_o && tick_i && is_last;

  always_comb begin
    if (rise_k <= PH_W'(CFG_W))        slot_o = SLOT_TX;
    else if (rise_k == PH_W'(NULL_K))  slot_o = SLOT_NULL;
    else if (rise_k <= PH_W'(MSB_END)) slot_o = SLOT_MSB;
    else                               slot_o = SLOT_LSB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b0;
      dout_o <= 1'b0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
      ph     <= '0;
      tx_sh  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          cs_n_o <= 1'b0;
          oe_o   <= 1'b1;
          dout_o <= 1'b1;          // start bit
          ph     <= '0;
          tx_sh  <= cfg_i;
        end
      end else if (tick_i) begin
        ph <= ph_nxt;
        if (is_last) begin
          busy_o <= 1'b0;
          cs_n_o <= 1'b1;
          sclk_o <= 1'b0;
          oe_o   <= 1'b0;
          dout_o <= 1'b0;
          done_o <= 1'b1;
        end else if (is_rise) begin
          sclk_o <= 1'b1;
        end else if (is_fall) begin
          sclk_o <= 1'b0;
          if (fall_k < PH_W'(CFG_W)) begin
            dout_o <= tx_sh[CFG_W-1];
            tx_sh  <= tx_sh << 1;
          end else if (fall_k == PH_W'(CFG_W)) begin
            oe_o   <= 1'b0;
            dout_o <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_link_capture.sv
module adc_link_capture
  import adc_link_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  slot_e            slot_i,
  input  logic             din_i,
  input  logic             fin_i,
  output logic [RES_W-1:0] result_o,
  output logic             mismatch_o
);
  logic [RES_W-1:0] msb_sh;
  logic [RES_W-2:0] rep_sh;   // rep_sh[i] holds repeat of result bit i+1

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_sh     <= '0;
      rep_sh     <= '0;
      result_o   <= '0;
      mismatch_o <= 1'b0;
    end else begin
      if (smp_i) begin
        case (slot_i)
          SLOT_MSB: msb_sh <= {msb_sh[RES_W-2:0], din_i};
          SLOT_LSB: rep_sh <= {din_i, rep_sh[RES_W-2:1]};
          default:  ;
        endcase
      end
      if (fin_i) begin
        result_o   <= msb_sh;
        mismatch_o <= (rep_sh != msb_sh[RES_W-1:1]);
      end
    end
  end
endmodule

// File: rtl/adc_link_host.sv
module adc_link_host
  import adc_link_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CFG_W    = 3,
  parameter int RES_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             mismatch_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  input  logic             sdata_i
);
  logic  tick, smp, fin;
  slot_e slot;

  adc_link_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  adc_link_seq #(.CFG_W(CFG_W), .RES_W(RES_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cfg_i   (cfg_i),
    .tick_i  (tick),
    .busy_o  (busy_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .dout_o  (sdata_o),
    .oe_o    (sdata_oe_o),
    .done_o  (done_o),
    .smp_o   (smp),
    .slot_o  (slot),
    .fin_o   (fin)
  );

  adc_link_capture #(.RES_W(RES_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .smp_i      (smp),
    .slot_i     (slot),
    .din_i      (sdata_i),
    .fin_i      (fin),
    .result_o   (result_o),
    .mismatch_o (mismatch_o)
  );
endmodule

// File: rtl/adc_link_host_chk.sv
module adc_link_host_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdata_oe_o
);
  assert_sclk_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_oe_inside_frame_R1: assert property (@(posedge clk) disable iff (rst)
    sdata_oe_o |-> !cs_n_o);

  assert_open_frame_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && !cs_n_o && sdata_oe_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_closes_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_n_o && !busy_o));

  assert_busy_ends_done_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_o) |=> !done_o || !busy_o);
endmodule

bind adc_link_host adc_link_host_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .sdata_oe_o (sdata_oe_o)
);

// File: tb/tb_adc_link_host.sv
`timescale 1ns/1ps
module tb_adc_link_host;
  localparam int H        = 2;
  localparam int CW       = 3;
  localparam int RW       = 8;
  localparam int N_RISE   = 2 + CW + 2 * RW - 1;
  localparam int BUSY_LEN = (2 * N_RISE + 2) * H;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [CW-1:0] cfg_i = '0;
  logic          busy_o, done_o, mismatch_o, cs_n_o, sclk_o, sdata_o, sdata_oe_o;
  logic [RW-1:0] result_o;
  logic          sdrv = 1'b0;

  always #2.5 clk = ~clk;

  adc_link_host #(.HALF_DIV(H), .CFG_W(CW), .RES_W(RW)) dut (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_i      (cfg_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .mismatch_o (mismatch_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .sdata_i    (sdrv)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int rise_idx = 0, cs_fall_cyc = 0, first_rise_cyc = 0;
  int oe_late_bad = 0, oe_early_bad = 0, idle_bad = 0;
  logic [3:0]    sent = '0;
  logic [RW-1:0] sv = '0;
  logic [RW-2:0] smask = '0;

  always @(posedge clk) cyc = cyc + 1;

  // converter model: watches the serial clock and answers on falling edges
  always @(negedge cs_n_o) begin
    cs_fall_cyc = cyc;
    rise_idx = 0;
    oe_late_bad = 0;
    oe_early_bad = 0;
  end

  always @(posedge sclk_o) begin
    if (rise_idx == 0) first_rise_cyc = cyc;
    if (rise_idx < 4) begin
      sent[3 - rise_idx] = sdata_o;
      if (!sdata_oe_o) oe_early_bad++;
    end else if (sdata_oe_o) begin
      oe_late_bad++;
    end
    rise_idx++;
  end

  always @(negedge sclk_o) begin
    int k;
    k = rise_idx;
    if (k >= 5 && k <= 12)       sdrv <= sv[12 - k];
    else if (k >= 13 && k <= 19) sdrv <= sv[k - 12] ^ smask[k - 13];
    else                         sdrv <= 1'b0;   // null bit and idle
  end

  always @(negedge clk) if (!rst && cs_n_o && sclk_o) idle_bad++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [RW-1:0] v, input logic [CW-1:0] c,
                         input logic [RW-2:0] m, input bit extra);
    int blen;
    sv = v;
    smask = m;
    @(negedge clk);
    start_i = 1'b1;
    cfg_i = c;
    @(negedge clk);
    start_i = 1'b0;
    cfg_i = ~c;                         // changing cfg_i must not matter
    check(!cs_n_o && busy_o, "R2", "frame opened", {cs_n_o, busy_o}, 1);
    blen = 0;
    while (busy_o && blen < 10000) begin
      blen++;
      start_i = (extra && blen == 5);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(blen == BUSY_LEN, "R6", "busy length", blen, BUSY_LEN);
    check(done_o == 1'b1, "R6", "done at frame end", done_o, 1);
    check(cs_n_o == 1'b1, "R6", "cs raised with done", cs_n_o, 1);
    check(rise_idx == N_RISE, "R6", "rising edges", rise_idx, N_RISE);
    check(first_rise_cyc - cs_fall_cyc == 2 * H, "R2", "lead-in clocks",
          first_rise_cyc - cs_fall_cyc, 2 * H);
    check(sent == {1'b1, c}, "R3", "start+cfg bits", sent, {1'b1, c});
    check(oe_early_bad == 0, "R3", "driver off while sending", oe_early_bad, 0);
    check(oe_late_bad == 0, "R4", "driver on after release", oe_late_bad, 0);
    check(result_o == v, "R5", "result", result_o, v);
    check(mismatch_o == (m != 0), "R7", "mismatch", mismatch_o, (m != 0));
    if (extra)
      check(blen == BUSY_LEN && sent == {1'b1, c} && result_o == v, "R8",
            "frame with start during busy", result_o, v);
    @(negedge clk);
    check(done_o == 1'b0, "R6", "done single cycle", done_o, 0);
    check(busy_o == 1'b0, "R8", "no second frame", busy_o, 0);
    check(result_o == v, "R5", "result held", result_o, v);
  endtask

  initial begin : watchdog
    wait (cyc >= WATCHDOG);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check(cs_n_o == 1'b1, "R1", "cs idle", cs_n_o, 1);
    check(sclk_o == 1'b0, "R1", "sclk idle", sclk_o, 0);
    check(sdata_oe_o == 1'b0, "R1", "oe idle", sdata_oe_o, 0);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done idle",
          {busy_o, done_o}, 0);

    // full sweep of result codes, clean link
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      run_txn(vb, vb[2:0] ^ vb[5:3], '0, (v % 37) == 3);
    end
    // single-bit corruption of each repeat position
    for (int j = 0; j < RW - 1; j++)
      run_txn(8'hA5 ^ 8'(j), 3'(j), 7'(1 << j), 1'b0);
    run_txn(8'h3C, 3'd5, 7'h7F, 1'b0);

    repeat (3) @(negedge clk);
    check(idle_bad == 0, "R1", "sclk high while cs high", idle_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule